// File: doc/BRIEF.md
# Fused Multiply-Add Addend Alignment and Sum Datapath

This block is the part of a fused multiply-add unit that brings the addend into place and forms the unrounded sum. It computes A·B ± C with a single final result, leaving normalisation and rounding to later stages. The block never shifts the product. The addend C is always the operand that moves. Its shift comes from the exponents alone, as d = EA + EB − EC, so the alignment runs alongside the product's carry-save reduction.

The sum is kept in a window of 3P+2 bits, in two's complement. The product occupies bits [2P−1:0]. The addend's least significant bit lands at bit P−d, for any d between −P and +P. The top P+2 bits receive only the aligned addend and a single incoming carry, so that part is an incrementer rather than a full adder. Addend bits that fall below bit 0 are dropped and recorded in a sticky flag. When the addend sits entirely above the product, the product itself is dropped and recorded in the same flag.

Typical uses: set C = 0 for a plain multiply, or B = 1 for a plain add. The subtract control negates the aligned addend before the 3:2 row. Outputs are registered, with a latency of one clock.

Top module: `fma_addend_align`

## Requirements
- R1: The outputs are registered with one cycle of latency, and an active-low reset forces the sum and the sticky flag to 0.
- R2: With sub_c = 0 and −P ≤ d ≤ P, sum_o equals A·B + C·2^(P−d) exactly, and its top bit is 0.
- R3: With sub_c = 1, sum_o equals A·B − Caligned modulo 2^(3P+2), in two's complement. Caligned is the aligned addend after any dropped low bits.
- R4: For d > P, the addend contributes floor(C / 2^(d−P)), and sticky_o is 1 exactly when a dropped addend bit is 1. For d ≥ 2P the addend contributes nothing.
- R5: For d < −P, the product is replaced by zero and the addend is placed as for d = −P, with its LSB at bit 2P. sticky_o is then 1 exactly when A ≠ 0 and B ≠ 0.
- R6: With C = 0 and d ≥ −P, sum_o equals A·B regardless of sub_c. With B = 1, the block performs a plain add or subtract of the aligned addend.
- R7: The carry out of the lower 2P bits into the upper part is at most 1. The upper P+2 bits equal the aligned (possibly negated) addend's upper bits plus that carry.
- R8: sticky_o is 0 whenever −P ≤ d ≤ P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sig | input | P | Multiplicand significand |
| b_sig | input | P | Multiplier significand |
| c_sig | input | P | Addend significand |
| a_exp | input | EW | Multiplicand exponent (unsigned) |
| b_exp | input | EW | Multiplier exponent (unsigned) |
| c_exp | input | EW | Addend exponent (unsigned) |
| sub_c | input | 1 | 1 = subtract the aligned addend |
| sum_o | output | 3P+2 | Unrounded sum window, two's complement |
| sticky_o | output | 1 | Some discarded operand bit was nonzero |

## Verification
The bench builds the block with P = 8 and EW = 6. This keeps every window value inside a 64-bit integer reference. It also lets a fixed pair of exponents reach every shift from −23 to +40 using only the addend exponent. Those settings bring within reach the full in-window sweep, both sticky boundaries (d = P versus P+1, and d = −P versus −(P+1)), the total addend spill at d ≥ 2P, and the all-ones negated addend whose carry must ripple through the whole incrementer.

// File: rtl/fmaa_pkg.sv
package fmaa_pkg;

    // Where the aligned addend falls relative to the sum window
    typedef enum logic [1:0] {
        ALN_WINDOW = 2'd0,  // fully inside, no bits lost
        ALN_SPILL  = 2'd1,  // low addend bits fall below bit 0
        ALN_DROP   = 2'd2   // addend above product: product discarded
    } aln_zone_e;

endpackage

// File: rtl/fmaa_pp_csa.sv
// Product of two P-bit significands kept as a carry-save pair.
// Linear array of 3:2 rows; every vector stays below 2^(2P), so the
// bit shifted off the top of each carry vector is always zero.
module fmaa_pp_csa #(
    parameter int P = 24
) (
    input  logic [P-1:0]   a_i,
    input  logic [P-1:0]   b_i,
    output logic [2*P-1:0] ps_o,
    output logic [2*P-1:0] pc_o
);
    localparam int PW = 2 * P;

    logic [PW-1:0] pp [P];
    logic [PW-1:0] st [1:P-1];
    logic [PW-1:0] ct [1:P-1];

    for (genvar gi = 0; gi < P; gi++) begin : g_pp
        assign pp[gi] = b_i[gi] ? (PW'(a_i) << gi) : '0;
    end

    assign st[1] = pp[0];
    assign ct[1] = pp[1];

    for (genvar gr = 2; gr < P; gr++) begin : g_row
        assign st[gr] = st[gr-1] ^ ct[gr-1] ^ pp[gr];
        assign ct[gr] = ((st[gr-1] & ct[gr-1]) | (st[gr-1] & pp[gr])
                       | (ct[gr-1] & pp[gr])) << 1;
    end

    assign ps_o = st[P-1];
    assign pc_o = ct[P-1];

endmodule

// File: rtl/fmaa_c_shift.sv
// Addend alignment from exponents only: LSB of C goes to window bit P-d,
// clamped to [-P, 2P]. Bits below bit 0 feed the sticky flag.
module fmaa_c_shift
    import fmaa_pkg::*;
#(
    parameter int P  = 24,
    parameter int EW = 8
) (
    input  logic [P-1:0]    c_i,
    input  logic [EW-1:0]   ea_i,
    input  logic [EW-1:0]   eb_i,
    input  logic [EW-1:0]   ec_i,
    input  logic            sub_i,
    output logic [3*P+1:0]  cal_o,
    output logic            lost_o,
    output aln_zone_e       zone_o
);
    localparam int SW  = 3 * P + 2;
    localparam int XW  = 4 * P;
    localparam int SHW = $clog2(3 * P + 1);

    int              diff;
    int              pos;
    int              posc;
    logic [SHW-1:0]  sh;
    logic [XW-1:0]   ext;
    logic [SW-1:0]   win;

    always_comb begin
        diff = int'(ea_i) + int'(eb_i) - int'(ec_i);
        pos  = P - diff;
        if (pos > 2 * P) begin
            posc   = 2 * P;
            zone_o = ALN_DROP;
        end else if (pos < 0) begin
            posc   = (pos < -P) ? -P : pos;
            zone_o = ALN_SPILL;
        end else begin
            posc   = pos;
            zone_o = ALN_WINDOW;
        end
        sh     = SHW'(posc + P);
        ext    = XW'(c_i) << sh;
        win    = SW'(ext[XW-1:P]);
        lost_o = |ext[P-1:0];
        cal_o  = sub_i ? ~win : win;
    end

endmodule

// File: rtl/fmaa_merge.sv
// 3:2 row over the lower 2P bits (product pair + aligned addend), a 2P-bit
// carry-propagate add, and an increment-only upper part.
module fmaa_merge #(
    parameter int P = 24
) (
    input  logic [2*P-1:0] ps_i,
    input  logic [2*P-1:0] pc_i,
    input  logic [3*P+1:0] cal_i,
    input  logic           inj_i,
    output logic [3*P+1:0] sum_o,
    output logic [1:0]     lo_cout_o
);
    localparam int PW = 2 * P;
    localparam int UW = P + 2;

    logic [PW-1:0] s3;
    logic [PW-1:0] mj;
    logic [PW:0]   c3;
    logic [PW+1:0] lo;
    logic [UW-1:0] up;

    always_comb begin
        s3 = ps_i ^ pc_i ^ cal_i[PW-1:0];
        mj = (ps_i & pc_i) | (ps_i & cal_i[PW-1:0]) | (pc_i & cal_i[PW-1:0]);
        c3 = (PW+1)'(mj) << 1;
        lo = (PW+2)'(s3) + (PW+2)'(c3) + (PW+2)'(inj_i);
        up = cal_i[3*P+1:PW] + UW'(lo[PW]);
        sum_o     = {up, lo[PW-1:0]};
        lo_cout_o = lo[PW+1:PW];
    end

endmodule

// File: rtl/fma_addend_align.sv
module fma_addend_align
    import fmaa_pkg::*;
#(
    parameter int P  = 24,
    parameter int EW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [P-1:0]     a_sig,
    input  logic [P-1:0]     b_sig,
    input  logic [P-1:0]     c_sig,
    input  logic [EW-1:0]    a_exp,
    input  logic [EW-1:0]    b_exp,
    input  logic [EW-1:0]    c_exp,
    input  logic             sub_c,
    output logic [3*P+1:0]   sum_o,
    output logic             sticky_o
);
    localparam int SW = 3 * P + 2;
    localparam int PW = 2 * P;

    typedef struct packed {
        logic [SW-1:0] sum;
        logic          sticky;
    } res_t;

    logic [PW-1:0] ps, pc, ps_m, pc_m;
    logic [SW-1:0] cal, msum;
    logic          lost;
    logic [1:0]    lo_cout;
    aln_zone_e     zone;
    res_t          res_d, res_q;

    fmaa_pp_csa #(.P(P)) u_pp (
        .a_i (a_sig),
        .b_i (b_sig),
        .ps_o(ps),
        .pc_o(pc)
    );

    fmaa_c_shift #(.P(P), .EW(EW)) u_shift (
        .c_i   (c_sig),
        .ea_i  (a_exp),
        .eb_i  (b_exp),
        .ec_i  (c_exp),
        .sub_i (sub_c),
        .cal_o (cal),
        .lost_o(lost),
        .zone_o(zone)
    );

    fmaa_merge #(.P(P)) u_merge (
        .ps_i     (ps_m),
        .pc_i     (pc_m),
        .cal_i    (cal),
        .inj_i    (sub_c),
        .sum_o    (msum),
        .lo_cout_o(lo_cout)
    );

    always_comb begin
        ps_m = (zone == ALN_DROP) ? '0 : ps;
        pc_m = (zone == ALN_DROP) ? '0 : pc;
        res_d.sum    = msum;
        res_d.sticky = lost | ((zone == ALN_DROP) && (a_sig != '0) && (b_sig != '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o    = res_q.sum;
    assign sticky_o = res_q.sticky;

    AST_ADD_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sub_c) |-> !sum_o[SW-1]); // R2
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(zone == ALN_DROP) |-> (sticky_o == $past((a_sig != '0) && (b_sig != '0)))); // R5
    AST_ZERO_ADDEND: assert property (@(posedge clk) disable iff (!rst_n)
        $past((c_sig == '0) && (zone != ALN_DROP)) |->
        (sum_o == SW'($past(a_sig)) * SW'($past(b_sig)))); // R6
    AST_LOW_CARRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cout[1] == 1'b0); // R7
    AST_NO_STICKY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(zone == ALN_WINDOW) |-> !sticky_o); // R8

endmodule

// File: tb/fma_addend_align_bench.sv
module fma_addend_align_bench;
    localparam int P  = 8;
    localparam int EW = 6;
    localparam int SW = 3 * P + 2;
    localparam longint MASK = (longint'(1) << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P-1:0]  a_sig = '0, b_sig = '0, c_sig = '0;
    logic [EW-1:0] a_exp = '0, b_exp = '0, c_exp = '0;
    logic          sub_c = 1'b0;
    logic [SW-1:0] sum_o;
    logic          sticky_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fma_addend_align #(.P(P), .EW(EW)) u_fma_addend_align (
        .clk(clk), .rst_n(rst_n),
        .a_sig(a_sig), .b_sig(b_sig), .c_sig(c_sig),
        .a_exp(a_exp), .b_exp(b_exp), .c_exp(c_exp),
        .sub_c(sub_c), .sum_o(sum_o), .sticky_o(sticky_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void ref_model(input longint a, input longint b, input longint c,
                                      input int d, input bit sub,
                                      output longint s, output bit st);
        int pos, pcl;
        bit drop, lost;
        longint cal, prod;
        pos  = P - d;
        drop = pos > 2 * P;
        pcl  = drop ? 2 * P : ((pos < -P) ? -P : pos);
        lost = 1'b0;
        if (pcl >= 0) cal = c << pcl;
        else begin
            cal  = c >> (-pcl);
            lost = (c & ((longint'(1) << (-pcl)) - 1)) != 0;
        end
        prod = drop ? 0 : a * b;
        s  = (sub ? prod - cal : prod + cal) & MASK;
        st = lost | (drop && a != 0 && b != 0);
    endfunction

    // shift d = 20 + 20 - (40 - d)
    task automatic drive(input int a, input int b, input int c, input int d, input bit sub);
        a_sig = P'(a); b_sig = P'(b); c_sig = P'(c);
        a_exp = EW'(20); b_exp = EW'(20); c_exp = EW'(40 - d);
        sub_c = sub;
    endtask

    task automatic run_vec(input int a, input int b, input int c, input int d,
                           input bit sub, input string req);
        longint es;
        bit est;
        @(negedge clk);
        drive(a, b, c, d, sub);
        @(negedge clk);
        ref_model(longint'(a), longint'(b), longint'(c), d, sub, es, est);
        check(longint'(sum_o) == es, req, longint'(sum_o), es);
        check(sticky_o == est, {req, " sticky"}, longint'(sticky_o), longint'(est));
    endtask

    task automatic t_reset;
        drive(8'hFF, 8'hFF, 8'h81, 12, 1'b1);
        repeat (3) @(negedge clk);
        check(sum_o == '0, "R1 reset sum", longint'(sum_o), 0);
        check(sticky_o == 1'b0, "R1 reset sticky", longint'(sticky_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        longint es;
        bit est;
        run_vec(3, 5, 0, 0, 1'b0, "R1 first");
        @(negedge clk);
        drive(7, 9, 0, 0, 1'b0);
        #2;
        check(longint'(sum_o) == 15, "R1 held before edge", longint'(sum_o), 15);
        @(negedge clk);
        ref_model(7, 9, 0, 0, 1'b0, es, est);
        check(longint'(sum_o) == es, "R1 after edge", longint'(sum_o), es);
    endtask

    task automatic t_window;
        for (int d = -P; d <= P; d++) run_vec(8'hB7, 8'h5D, 8'hC3, d, 1'b0, "R2 R8 window");
        run_vec(8'hFF, 8'hFF, 8'hFF, -P, 1'b0, "R2 top");
    endtask

    task automatic t_sub;
        run_vec(8'hB7, 8'h5D, 8'hC3, -P, 1'b1, "R3 negative");
        run_vec(8'hB7, 8'h5D, 8'h13, 0, 1'b1, "R3 mid");
        run_vec(8'hB7, 8'h5D, 8'hC3, 3, 1'b1, "R3 pos");
        run_vec(8'hB7, 8'h5D, 8'hC3, P, 1'b1, "R3 low edge");
        run_vec(8'hB7, 8'h5D, 8'hC5, P + 3, 1'b1, "R3 spill sub");
    endtask

    task automatic t_spill;
        run_vec(8'h11, 8'h22, 8'h81, P, 1'b0, "R4 at P");
        run_vec(8'h11, 8'h22, 8'h81, P + 1, 1'b0, "R4 P+1 odd");
        run_vec(8'h11, 8'h22, 8'h82, P + 1, 1'b0, "R4 P+1 even");
        run_vec(8'h11, 8'h22, 8'h80, P + 7, 1'b0, "R4 top bit only");
        run_vec(8'h11, 8'h22, 8'h01, 2 * P, 1'b0, "R4 all out");
        run_vec(8'h11, 8'h22, 8'hFF, 20, 1'b0, "R4 far");
    endtask

    task automatic t_drop;
        run_vec(8'h9A, 8'h37, 8'hE1, -P, 1'b0, "R5 at -P");
        run_vec(8'h9A, 8'h37, 8'hE1, -P - 1, 1'b0, "R5 drop");
        run_vec(8'h00, 8'h37, 8'hE1, -P - 1, 1'b0, "R5 drop a zero");
        run_vec(8'h9A, 8'h00, 8'hE1, -P - 5, 1'b1, "R5 drop sub");
        run_vec(8'h9A, 8'h37, 8'hE1, -20, 1'b1, "R5 far drop");
    endtask

    task automatic t_modes;
        run_vec(8'hD3, 8'hA9, 8'h00, -3, 1'b0, "R6 mul only");
        run_vec(8'hD3, 8'hA9, 8'h00, 5, 1'b1, "R6 mul only sub");
        run_vec(8'hD3, 8'h01, 8'h6E, 2, 1'b0, "R6 add only");
        run_vec(8'hD3, 8'h01, 8'h6E, -2, 1'b1, "R6 sub only");
    endtask

    task automatic t_carry;
        run_vec(8'hFF, 8'hFF, 8'hFF, 0, 1'b0, "R7 carry up");
        run_vec(8'hFF, 8'hFF, 8'hFF, -1, 1'b0, "R7 split carry");
        run_vec(8'hFF, 8'hFF, 8'h00, 0, 1'b1, "R7 ripple through upper");
        run_vec(8'hFF, 8'hFF, 8'h01, P, 1'b1, "R7 borrow");
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            int d;
            d = int'($urandom_range(0, 36)) - 14;
            run_vec(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 255)), d, 1'($urandom_range(0, 1)), "R3 R4 R5 mixed");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_latency;
        t_window;
        t_sub;
        t_spill;
        t_drop;
        t_modes;
        t_carry;
        t_random;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule